// File: doc/BRIEF.md
# Time-Step Sequenced Accumulator Controller

This block is the control unit of a small accumulator machine, built as three cooperating pieces instead of one large state graph. A shared eight-step timer walks every instruction through the same skeleton. The two-bit opcode held in the instruction register and the sign bit of the accumulator are supplied from outside as plain levels. The block decodes them together with the current time step, so each control strobe is a sum of time-step terms, each gated by opcode or sign terms.

The datapath registers (program counter, memory address and buffer registers, instruction register, accumulator) and the memory lie outside the block. They act on the strobes at the clock edge that ends the step in which a strobe is high. The memory acknowledges through an already-synchronized busy line. The block keeps the current step visible as a 3-bit index so that surrounding logic can follow the sequence.

Top module: `tsc_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `pc_clear` is 1 and every other strobe is 0. In the cycle after a reset edge, `step_o` is 0.
- R2: In step 0, `pc_to_mar` and `pc_incr` are both 1. Step 0 is always followed by step 1.
- R3: In step 2, `mem_req`, `mem_rnw` and `mem_to_mbr` are 1. The step repeats while `mem_wait` is sampled high and moves to step 3 on the first edge at which it is low.
- R4: In step 4, only `mbr_to_ir` is high.
- R5: In step 5, `ir_to_mar` is 1 for opcodes 00 (load), 01 (store) and 10 (add), and `ac_to_mbr` is 1 for store only. Opcode 11 (branch) raises nothing.
- R6: In step 6, load and add raise `mem_req`, `mem_rnw` and `mem_to_mbr`. Store raises `mem_req` and `mbr_to_mem` with `mem_rnw` at 0. For these three opcodes the step repeats while `mem_wait` is high.
- R7: In step 6, a branch raises `ir_to_pc` exactly when `ac_sign` is 1 and raises nothing when it is 0. Either way, the next step is 0.
- R8: In step 7, load raises `mbr_to_ac` and add raises `ac_add_mbr`. Step 7 is always followed by step 0.
- R9: Steps 1, 3, 4 and 5 each last one cycle and advance by one. Step 6 for store ends in step 0, and for load or add ends in step 7. Any strobe not named for a step is 0, and steps 1 and 3 raise no strobe.
- R10: `mem_wait` has no effect on the sequence outside step 2 and the memory form of step 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_wait | input | 1 | Synchronized memory busy indication |
| ir_op | input | 2 | Opcode bits of the instruction register |
| ac_sign | input | 1 | Sign bit of the accumulator |
| step_o | output | 3 | Current time step index, 0 to 7 |
| pc_clear | output | 1 | Clear the program counter |
| pc_incr | output | 1 | Increment the program counter |
| pc_to_mar | output | 1 | Copy the program counter into the address register |
| mem_req | output | 1 | Memory request |
| mem_rnw | output | 1 | Memory direction, 1 read, 0 write |
| mem_to_mbr | output | 1 | Capture memory data into the buffer register |
| mbr_to_mem | output | 1 | Drive the buffer register onto the memory data bus |
| mbr_to_ir | output | 1 | Copy the buffer register into the instruction register |
| ir_to_mar | output | 1 | Copy the instruction address field into the address register |
| ac_to_mbr | output | 1 | Copy the accumulator into the buffer register |
| ir_to_pc | output | 1 | Copy the instruction address field into the program counter |
| mbr_to_ac | output | 1 | Copy the buffer register into the accumulator |
| ac_add_mbr | output | 1 | Write accumulator plus buffer register into the accumulator |

## Verification
The assertions assume that `ir_op` and `ac_sign` are stable from step 5 to the end of the instruction, as they are when the instruction register and the accumulator change only at the edges this controller commands. They also assume that `mem_wait` arrives already synchronized to `clk`. The bench changes the opcode and sign only between instructions and drives every input one time unit after the rising edge. It raises `mem_wait` freely in steps where it must be ignored, and for chosen numbers of cycles in the two memory steps. It also applies one reset in the middle of an instruction.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int STEPS  = 8;
    localparam int STEP_W = $clog2(STEPS);
    localparam int OP_W   = 2;

    typedef enum logic [STEP_W-1:0] {
        T0 = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3,
        T4 = 3'd4, T5 = 3'd5, T6 = 3'd6, T7 = 3'd7
    } tstep_e;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_ADD    = 2'b10,
        OP_BRANCH = 2'b11
    } op_e;

    typedef struct packed {
        logic pc_clear;
        logic pc_incr;
        logic pc_to_mar;
        logic mem_req;
        logic mem_rnw;
        logic mem_to_mbr;
        logic mbr_to_mem;
        logic mbr_to_ir;
        logic ir_to_mar;
        logic ac_to_mbr;
        logic ir_to_pc;
        logic mbr_to_ac;
        logic ac_add_mbr;
    } strobe_t;

    function automatic logic touches_memory(op_e op);
        return op != OP_BRANCH;
    endfunction

    function automatic logic reads_memory(op_e op);
        return (op == OP_LOAD) || (op == OP_ADD);
    endfunction
endpackage

// File: rtl/tsc_timer.sv
module tsc_timer
    import tsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mem_wait,
    input  op_e    op,
    output tstep_e step
);
    tstep_e step_q, step_d;

    always_comb begin
        step_d = step_q;
        unique case (step_q)
            T0: step_d = T1;
            T1: step_d = T2;
            T2: step_d = mem_wait ? T2 : T3;
            T3: step_d = T4;
            T4: step_d = T5;
            T5: step_d = T6;
            T6: begin
                if (!touches_memory(op))  step_d = T0;
                else if (mem_wait)        step_d = T6;
                else if (op == OP_STORE)  step_d = T0;
                else                      step_d = T7;
            end
            T7: step_d = T0;
            default: step_d = T0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= T0;
        else     step_q <= step_d;
    end

    assign step = step_q;

    p_t0_next_r2: assert property (@(posedge clk) disable iff (rst)
        step_q == T0 |=> step_q == T1);
    p_fetch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (step_q == T2 && mem_wait) |=> step_q == T2);
    p_branch_end_r7: assert property (@(posedge clk) disable iff (rst)
        (step_q == T6 && op == OP_BRANCH) |=> step_q == T0);
    p_t7_end_r8: assert property (@(posedge clk) disable iff (rst)
        step_q == T7 |=> step_q == T0);
    p_exec_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (step_q == T6 && op != OP_BRANCH && mem_wait) |=> step_q == T6);
endmodule

// File: rtl/tsc_decode.sv
module tsc_decode
    import tsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tstep_e  step,
    input  op_e     op,
    input  logic    neg,
    output strobe_t strobes
);
    logic [STEPS-1:0] t;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        assign t[i] = (step == tstep_e'(i));
    end

    logic is_ld, is_st, is_add, is_br;
    assign is_ld  = (op == OP_LOAD);
    assign is_st  = (op == OP_STORE);
    assign is_add = (op == OP_ADD);
    assign is_br  = (op == OP_BRANCH);

    always_comb begin
        strobes          = '0;
        strobes.pc_clear = rst;
        if (!rst) begin
            strobes.pc_incr    = t[0];
            strobes.pc_to_mar  = t[0];
            strobes.mem_req    = t[2] | (t[6] & touches_memory(op));
            strobes.mem_rnw    = t[2] | (t[6] & reads_memory(op));
            strobes.mem_to_mbr = t[2] | (t[6] & reads_memory(op));
            strobes.mbr_to_mem = t[6] & is_st;
            strobes.mbr_to_ir  = t[4];
            strobes.ir_to_mar  = t[5] & touches_memory(op);
            strobes.ac_to_mbr  = t[5] & is_st;
            strobes.ir_to_pc   = t[6] & is_br & neg;
            strobes.mbr_to_ac  = t[7] & is_ld;
            strobes.ac_add_mbr = t[7] & is_add;
        end
    end

    p_write_dir_r6: assert property (@(posedge clk) disable iff (rst)
        strobes.mbr_to_mem |-> (strobes.mem_req && !strobes.mem_rnw));
    p_acc_single_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strobes.mbr_to_ac, strobes.ac_add_mbr, strobes.ac_to_mbr}));
    p_pc_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strobes.pc_incr, strobes.ir_to_pc, strobes.pc_clear}));
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_wait,
    input  logic [OP_W-1:0]   ir_op,
    input  logic              ac_sign,
    output logic [STEP_W-1:0] step_o,
    output logic              pc_clear,
    output logic              pc_incr,
    output logic              pc_to_mar,
    output logic              mem_req,
    output logic              mem_rnw,
    output logic              mem_to_mbr,
    output logic              mbr_to_mem,
    output logic              mbr_to_ir,
    output logic              ir_to_mar,
    output logic              ac_to_mbr,
    output logic              ir_to_pc,
    output logic              mbr_to_ac,
    output logic              ac_add_mbr
);
    tstep_e  step;
    strobe_t s;
    op_e     op;

    assign op = op_e'(ir_op);

    tsc_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .mem_wait (mem_wait),
        .op       (op),
        .step     (step)
    );

    tsc_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .op      (op),
        .neg     (ac_sign),
        .strobes (s)
    );

    assign step_o     = step;
    assign pc_clear   = s.pc_clear;
    assign pc_incr    = s.pc_incr;
    assign pc_to_mar  = s.pc_to_mar;
    assign mem_req    = s.mem_req;
    assign mem_rnw    = s.mem_rnw;
    assign mem_to_mbr = s.mem_to_mbr;
    assign mbr_to_mem = s.mbr_to_mem;
    assign mbr_to_ir  = s.mbr_to_ir;
    assign ir_to_mar  = s.ir_to_mar;
    assign ac_to_mbr  = s.ac_to_mbr;
    assign ir_to_pc   = s.ir_to_pc;
    assign mbr_to_ac  = s.mbr_to_ac;
    assign ac_add_mbr = s.ac_add_mbr;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |-> (pc_clear && !pc_incr && !mem_req && !mbr_to_ir && !ir_to_pc));
endmodule

// File: tb/test_tsc_ctrl.sv
module test_tsc_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_wait = 1'b0;
    logic [1:0] ir_op = 2'b00;
    logic       ac_sign = 1'b0;
    logic [2:0] step_o;
    logic pc_clear, pc_incr, pc_to_mar, mem_req, mem_rnw, mem_to_mbr, mbr_to_mem;
    logic mbr_to_ir, ir_to_mar, ac_to_mbr, ir_to_pc, mbr_to_ac, ac_add_mbr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_ctrl i_tsc_ctrl (
        .clk(clk), .rst(rst), .mem_wait(mem_wait), .ir_op(ir_op), .ac_sign(ac_sign),
        .step_o(step_o), .pc_clear(pc_clear), .pc_incr(pc_incr), .pc_to_mar(pc_to_mar),
        .mem_req(mem_req), .mem_rnw(mem_rnw), .mem_to_mbr(mem_to_mbr),
        .mbr_to_mem(mbr_to_mem), .mbr_to_ir(mbr_to_ir), .ir_to_mar(ir_to_mar),
        .ac_to_mbr(ac_to_mbr), .ir_to_pc(ir_to_pc), .mbr_to_ac(mbr_to_ac),
        .ac_add_mbr(ac_add_mbr)
    );

    int checks = 0;
    int fails  = 0;
    int mstep  = -1;
    bit done   = 0;
    int unsigned rng = 32'h1234_5678;

    function automatic int unsigned next_rand();
        rng = rng * 32'd1103515245 + 32'd12345;
        return rng >> 8;
    endfunction

    // Expected strobes, order: clear incr pc2mar req rnw m2mbr mbr2m mbr2ir ir2mar ac2mbr ir2pc mbr2ac add
    function automatic logic [12:0] expect_strobes(int st, logic r, logic [1:0] op, logic s);
        logic [12:0] e = '0;
        if (r) return 13'b1_0000_0000_0000;
        case (st)
            0: begin e[11] = 1; e[10] = 1; end
            2: begin e[9] = 1; e[8] = 1; e[7] = 1; end
            4: e[5] = 1;
            5: begin
                if (op != 2'b11) e[4] = 1;
                if (op == 2'b01) e[3] = 1;
            end
            6: begin
                if (op == 2'b00 || op == 2'b10) begin e[9] = 1; e[8] = 1; e[7] = 1; end
                else if (op == 2'b01) begin e[9] = 1; e[6] = 1; end
                else if (s) e[2] = 1;
            end
            7: begin
                if (op == 2'b00) e[1] = 1;
                if (op == 2'b10) e[0] = 1;
            end
            default: ;
        endcase
        return e;
    endfunction

    function automatic int model_next(int st, logic r, logic w, logic [1:0] op);
        if (r) return 0;
        if (st == 2) return w ? 2 : 3;
        if (st == 6) begin
            if (op == 2'b11) return 0;
            if (w) return 6;
            return (op == 2'b01) ? 0 : 7;
        end
        if (st == 7) return 0;
        return st + 1;
    endfunction

    function automatic string strobe_tag(int st, logic r, logic [1:0] op);
        if (r) return "R1";
        case (st)
            0: return "R2";
            2: return "R3";
            4: return "R4";
            5: return "R5";
            6: return (op == 2'b11) ? "R7" : "R6";
            7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic cycle(input logic r, input logic w, input logic [1:0] op, input logic s);
        logic [12:0] act, exp_s;
        string tag;
        rst = r; mem_wait = w; ir_op = op; ac_sign = s;
        @(negedge clk);
        act = {pc_clear, pc_incr, pc_to_mar, mem_req, mem_rnw, mem_to_mbr, mbr_to_mem,
               mbr_to_ir, ir_to_mar, ac_to_mbr, ir_to_pc, mbr_to_ac, ac_add_mbr};
        exp_s = expect_strobes(mstep, r, op, s);
        tag = strobe_tag(mstep, r, op);
        if (mstep >= 0 || r) begin
            checks++;
            if (act !== exp_s) begin
                fails++;
                $display("FAIL %s strobes step %0d: actual %b expected %b", tag, mstep, act, exp_s);
            end
        end
        if (mstep >= 0) begin
            checks++;
            if (step_o !== 3'(mstep)) begin
                fails++;
                $display("FAIL R9/R10 step index: actual %0d expected %0d", step_o, mstep);
            end
        end
        @(posedge clk);
        mstep = model_next(mstep, r, w, op);
        #1;
    endtask

    // Runs one instruction from step 0 back to step 0; noise drives mem_wait
    // high in steps where it must be ignored (R10).
    task automatic run_instr(input logic [1:0] op, input logic s, input int fetch_wait,
                             input int exec_wait, input logic noise);
        int fw = fetch_wait;
        int ew = exec_wait;
        int guard = 0;
        do begin
            logic w;
            if (mstep == 2) begin
                w = (fw > 0);
                if (fw > 0) fw--;
            end else if (mstep == 6 && op != 2'b11) begin
                w = (ew > 0);
                if (ew > 0) ew--;
            end else begin
                w = noise;
            end
            cycle(1'b0, w, op, s);
            guard++;
        end while (mstep != 0 && guard < 100);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1;
        // R1: reset state
        cycle(1'b1, 1'b0, 2'b00, 1'b0);
        cycle(1'b1, 1'b1, 2'b11, 1'b1);
        // R2..R8 directed instructions
        run_instr(2'b00, 1'b0, 2, 3, 1'b0);   // load, waits in both memory steps
        run_instr(2'b01, 1'b0, 0, 2, 1'b1);   // store, R6 write, R9 end at step 0
        run_instr(2'b10, 1'b1, 1, 0, 1'b1);   // add, R8
        run_instr(2'b11, 1'b1, 0, 0, 1'b1);   // branch taken, R7, R10 wait ignored
        run_instr(2'b11, 1'b0, 3, 0, 1'b1);   // branch not taken, R7
        run_instr(2'b01, 1'b1, 0, 0, 1'b0);   // store without wait
        for (int i = 0; i < 60; i++) begin
            logic [1:0] op = 2'(next_rand());
            logic s  = next_rand() % 2 == 1;
            int fw   = int'(next_rand() % 4);
            int ew   = int'(next_rand() % 4);
            logic nz = next_rand() % 2 == 1;
            run_instr(op, s, fw, ew, nz);
        end
        // R1: reset in the middle of a stalled store
        cycle(1'b0, 1'b0, 2'b01, 1'b0);
        for (int k = 0; k < 5; k++) cycle(1'b0, 1'b0, 2'b01, 1'b0);
        cycle(1'b0, 1'b1, 2'b01, 1'b0);
        cycle(1'b1, 1'b1, 2'b01, 1'b0);
        run_instr(2'b10, 1'b0, 1, 1, 1'b0);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule